// File: doc/BRIEF.md
# Sixteen-Bit Lookahead Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a small processor datapath. It takes two operands and a set of conditioning bits. Either operand can be complemented before use, and a carry-in is applied to the adder. A three-bit operation code picks which result is driven out. With these conditioning bits, one adder gives addition, A minus B and B minus A. The same conditioned operands also feed the bitwise AND, OR, NOR and XOR paths.

The datapath is split into identical slices. Each slice resolves its carries internally with full generate/propagate lookahead. The carry then ripples from one slice to the next. A zero flag reports an all-zero result, which suits equality tests for conditional branches. By default there are four slices of four bits each. The slice width and the slice count are parameters.

Top module: `cla_alu`

## Requirements
- R1: With op_sel = 000, inv_a = 0 and inv_b = 0, result equals (opnd_a + opnd_b + carry_in) modulo 2^16.
- R2: With op_sel = 000, inv_b = 1, inv_a = 0 and carry_in = 1, result equals (opnd_a - opnd_b) modulo 2^16.
- R3: With op_sel = 000, inv_a = 1, inv_b = 0 and carry_in = 1, result equals (opnd_b - opnd_a) modulo 2^16.
- R4: op_sel = 001 gives the bitwise AND of the two conditioned operands.
- R5: op_sel = 010 gives the bitwise OR of the two conditioned operands.
- R6: op_sel = 011 gives the bitwise NOR of the two conditioned operands.
- R7: op_sel = 100 gives the bitwise XOR of the two conditioned operands.
- R8: op_sel codes 101, 110 and 111 give an all-zero result.
- R9: carry_out is bit 16 of the sum of the conditioned operands plus carry_in, whatever op_sel selects.
- R10: zero is 1 exactly when all 16 result bits are 0.
- R11: The conditioning is applied before every operation. When inv_a is set, the complement of opnd_a is used, and when inv_b is set, the complement of opnd_b is used. This holds for the logic codes as well.
- R12: A carry made in the lowest bit travels through every slice boundary. For example, opnd_a = FFFF, opnd_b = 0000 and carry_in = 1 with an add gives result 0000, carry_out 1 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 3 | Operation code |
| inv_a | input | 1 | Use the complement of opnd_a |
| inv_b | input | 1 | Use the complement of opnd_b |
| carry_in | input | 1 | Carry into the lowest bit of the adder |
| result | output | 16 | Selected result |
| carry_out | output | 1 | Carry out of the top bit of the adder |
| zero | output | 1 | High when result is all zero |

## Verification
Every output is combinational, so each result is due in the same cycle that its stimulus is applied, with no register in between. The bench drives a new input vector just after a rising edge. It compares result, carry_out and zero against its behavioural model at the following falling edge, when the logic has had half a period to settle. Directed vectors cover each operation code, both subtraction orders, the unused codes and full carry propagation. After those, a pseudo-random sweep compares every cycle.

// File: rtl/cla_alu_pkg.sv
package cla_alu_pkg;
   typedef enum logic [2:0] {
      OP_ARITH = 3'b000,
      OP_AND   = 3'b001,
      OP_OR    = 3'b010,
      OP_NOR   = 3'b011,
      OP_XOR   = 3'b100
   } op_sel_e;
endpackage

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   initial begin
      if (W < 1 || W > 16) $error("cla_adder: W out of range");
   end

   logic [W-1:0] gen, prp;
   logic [W:0]   cy;

   assign gen = a & b;
   assign prp = a ^ b;

   // each carry is formed directly from the generate/propagate terms and cin
   always_comb begin
      cy[0] = cin;
      for (int i = 0; i < W; i++) begin
         logic acc;
         logic pr;
         acc = gen[i];
         pr  = prp[i];
         for (int j = i - 1; j >= 0; j--) begin
            acc = acc | (pr & gen[j]);
            pr  = pr & prp[j];
         end
         cy[i+1] = acc | (pr & cin);
      end
   end

   assign sum  = prp ^ cy[W-1:0];
   assign cout = cy[W];

   always_comb begin
      if (!$isunknown({a, b, cin}))
         p_slice_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("lookahead sum mismatch");
   end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
   import cla_alu_pkg::*;
#(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   sel,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);
   logic [W-1:0] add_q;

   cla_adder #(.W(W)) u_add (
      .a(a), .b(b), .cin(cin), .sum(add_q), .cout(cout)
   );

   always_comb begin
      unique case (sel)
         OP_ARITH: res = add_q;
         OP_AND:   res = a & b;
         OP_OR:    res = a | b;
         OP_NOR:   res = ~(a | b);
         OP_XOR:   res = a ^ b;
         default:  res = '0;
      endcase
   end
endmodule

// File: rtl/cla_alu.sv
module cla_alu
   import cla_alu_pkg::*;
#(
   parameter int SLICE_W    = 4,
   parameter int NUM_SLICES = 4
) (
   input  logic [15:0] opnd_a,
   input  logic [15:0] opnd_b,
   input  logic [2:0]  op_sel,
   input  logic        inv_a,
   input  logic        inv_b,
   input  logic        carry_in,
   output logic [15:0] result,
   output logic        carry_out,
   output logic        zero
);
   localparam int WIDTH = SLICE_W * NUM_SLICES;

   initial begin
      if (WIDTH != 16) $error("cla_alu: slices must cover 16 bits");
      if (SLICE_W < 1) $error("cla_alu: SLICE_W must be positive");
   end

   logic [WIDTH-1:0]  ca, cb;
   logic [NUM_SLICES:0] chain;

   assign ca       = inv_a ? ~opnd_a : opnd_a;
   assign cb       = inv_b ? ~opnd_b : opnd_b;
   assign chain[0] = carry_in;

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      alu_slice #(.W(SLICE_W)) u_slice (
         .a   (ca[s*SLICE_W +: SLICE_W]),
         .b   (cb[s*SLICE_W +: SLICE_W]),
         .sel (op_sel),
         .cin (chain[s]),
         .res (result[s*SLICE_W +: SLICE_W]),
         .cout(chain[s+1])
      );
   end

   assign carry_out = chain[NUM_SLICES];
   assign zero      = ~|result;

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_sel, inv_a, inv_b, carry_in})) begin
         p_unused_zero_r8: assert (op_sel <= 3'b100 || result == '0)
            else $error("unused code gave nonzero result");
         p_sub_ab_r2: assert (!(op_sel == OP_ARITH && !inv_a && inv_b && carry_in)
                              || result == opnd_a - opnd_b)
            else $error("A-B wrong");
         p_sub_ba_r3: assert (!(op_sel == OP_ARITH && inv_a && !inv_b && carry_in)
                              || result == opnd_b - opnd_a)
            else $error("B-A wrong");
         p_carry_r9: assert (carry_out == ((17'(ca) + 17'(cb) + 17'(carry_in)) >> 16))
            else $error("carry_out wrong");
         p_zero_and_r10: assert (!(op_sel == OP_AND && zero) || (ca & cb) == '0)
            else $error("zero flag set with nonzero AND");
      end
   end
endmodule

// File: tb/tb_cla_alu.sv
module tb_cla_alu;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic [2:0]  op_sel = '0;
   logic        inv_a = 1'b0, inv_b = 1'b0, carry_in = 1'b0;
   logic [15:0] result;
   logic        carry_out, zero;
   int total = 0, bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   cla_alu dut (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .inv_a(inv_a),
      .inv_b(inv_b), .carry_in(carry_in), .result(result),
      .carry_out(carry_out), .zero(zero)
   );

   task automatic model(output logic [15:0] r, output logic c, output logic z);
      int ea, eb, s;
      ea = inv_a ? (opnd_a ^ 16'hFFFF) : opnd_a;
      eb = inv_b ? (opnd_b ^ 16'hFFFF) : opnd_b;
      s  = ea + eb + carry_in;
      c  = s[16];
      case (op_sel)
         3'd0: r = s[15:0];
         3'd1: r = 16'(ea & eb);
         3'd2: r = 16'(ea | eb);
         3'd3: r = 16'(~(ea | eb));
         3'd4: r = 16'(ea ^ eb);
         default: r = 16'h0;
      endcase
      z = (r == 16'h0);
   endtask

   task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] sel,
                        input logic ia, input logic ib, input logic ci, input string tag);
      logic [15:0] er;
      logic ec, ez;
      @(posedge clk);
      #1;
      opnd_a = a; opnd_b = b; op_sel = sel; inv_a = ia; inv_b = ib; carry_in = ci;
      @(negedge clk);
      model(er, ec, ez);
      total++;
      if (result !== er || carry_out !== ec || zero !== ez) begin
         bad++;
         $display("FAIL %s: got res=%h co=%b z=%b expected res=%h co=%b z=%b",
                  tag, result, carry_out, zero, er, ec, ez);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      apply(16'h0000, 16'h0000, 3'd0, 0, 0, 0, "R10 reset-like zero");
      apply(16'h1234, 16'h4321, 3'd0, 0, 0, 0, "R1 add");
      apply(16'h8000, 16'h8000, 3'd0, 0, 0, 0, "R1 R9 add carry");
      apply(16'h0005, 16'h0003, 3'd0, 0, 1, 1, "R2 a-b");
      apply(16'h0003, 16'h0005, 3'd0, 0, 1, 1, "R2 a-b negative");
      apply(16'h0007, 16'h0007, 3'd0, 0, 1, 1, "R2 R10 equal");
      apply(16'h0005, 16'h0003, 3'd0, 1, 0, 1, "R3 b-a");
      apply(16'h0F0F, 16'h00FF, 3'd1, 0, 0, 0, "R4 and");
      apply(16'h0F00, 16'h00F0, 3'd1, 0, 0, 0, "R4 R10 and zero");
      apply(16'h0F0F, 16'h00FF, 3'd2, 0, 0, 0, "R5 or");
      apply(16'h0F0F, 16'h00FF, 3'd3, 0, 0, 0, "R6 nor");
      apply(16'hA5A5, 16'hFFFF, 3'd4, 0, 0, 0, "R7 xor");
      apply(16'hFFFF, 16'hFFFF, 3'd5, 0, 0, 0, "R8 code5");
      apply(16'h1234, 16'h5678, 3'd6, 1, 1, 1, "R8 code6");
      apply(16'hFFFF, 16'h0001, 3'd7, 0, 0, 0, "R8 R9 code7");
      apply(16'hFFFF, 16'h0001, 3'd1, 0, 0, 0, "R9 carry under and");
      apply(16'h0F0F, 16'h00FF, 3'd1, 1, 0, 0, "R11 inv_a and");
      apply(16'h0F0F, 16'h00FF, 3'd2, 0, 1, 0, "R11 inv_b or");
      apply(16'hFFFF, 16'h0000, 3'd0, 0, 0, 1, "R12 full propagate");
      for (int i = 0; i < 400; i++) begin
         logic [15:0] ra, rb;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ra = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rb = lfsr;
         apply(ra, rb, 3'(i % 8), rb[0], ra[1], ra[2] ^ rb[3], "R1 R9 R11 sweep");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule